// File: doc/BRIEF.md
# Exception Entry and Vectoring Sequencer

This block sits beside a CPU pipeline and handles the moment when an event breaks normal flow. At an instruction boundary the core raises `eval_i` and presents its current status word, program counter, stack register (general register 15), vector base, delay-slot state, sleep state and any pending exception code. An external interrupt priority controller supplies a pending-interrupt request and, for the mask exported on `ic_imask_o`, an interrupt vector with a valid flag. The sequencer decides whether an exception, an interrupt or nothing is taken. It then commits the whole entry in a single clock: the saved copies of status, return address and stack register, the new status word, the event code and the handler address.

The control is a two-state machine. `ST_IDLE` waits for a request. The transition `T_COMMIT` (IDLE to ENTRY) fires when a request yields an event, and all architectural outputs load on that edge. `ST_ENTRY` lasts exactly one cycle and drives the taken pulse. The transition `T_RETURN` (ENTRY to IDLE) is unconditional. A request that yields no event keeps the machine in IDLE (transition `T_HOLD`), and every output keeps its value.

Top module: `exc_entry_seq`

## Requirements
- R1: An exception code other than all ones (0xFFF) always wins over an interrupt request presented in the same cycle; INTEVT is then left unchanged and EXPEVT receives the exception code.
- R2: With SR bit 28 (block) set, any pending exception code other than 0x1E0 is taken as code 0x000 (EXPEVT = 0x000, PC = 0xA0000000); code 0x1E0 is taken unchanged and vectors to VBR+0x100.
- R3: With SR bit 28 set and no exception pending, an interrupt request is ignored (no taken pulse, outputs unchanged) unless the sleep input is high.
- R4: `ic_imask_o` always equals SR bits 7:4 of the presented status word; an interrupt is taken only when `ic_valid_i` is high, and otherwise nothing changes.
- R5: On every taken event SSR receives the presented SR, SGR receives R15, and the new SR equals the old SR with bits 30 (privileged), 29 (bank) and 28 (block) set.
- R6: When the delay-slot input is high, SPC is the presented PC minus 2 and `dslot_clr_o` pulses together with the taken pulse; otherwise SPC equals PC (apart from R9) and `dslot_clr_o` stays low.
- R7: Exception codes 0x000, 0x020 and 0x140 clear SR bit 15 (FPU disable), set SR bits 7:4 to 0xF and set PC to 0xA0000000.
- R8: Exception codes 0x040 and 0x060 set PC to VBR+0x400; every other exception code not named in R7 sets PC to VBR+0x100; EXPEVT receives the taken code.
- R9: For exception code 0x160, SPC is advanced by 2 on top of any R6 adjustment, and PC is VBR+0x100.
- R10: A taken interrupt writes the controller vector into INTEVT and sets PC to VBR+0x600, leaving EXPEVT unchanged.
- R11: A request that yields an event produces `taken_o` and `sleep_clr_o` high for exactly one cycle, in the cycle after `eval_i`, with all outputs updated in that same cycle; a request presented while `taken_o` is high is ignored.
- R12: With exception code 0xFFF and no interrupt request, a request takes nothing and all outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eval_i | input | 1 | Evaluate pending events this cycle |
| sr_i | input | XLEN | Current status word |
| pc_i | input | XLEN | Current program counter |
| r15_i | input | XLEN | Current general register 15 |
| vbr_i | input | XLEN | Vector base |
| in_dslot_i | input | 1 | Current instruction sits in a delay slot |
| sleep_i | input | 1 | Core is sleeping |
| exc_code_i | input | CODE_W | Pending exception code, all ones when none |
| irq_req_i | input | 1 | Interrupt pending at the controller |
| ic_imask_o | output | 4 | Current interrupt mask to the controller |
| ic_vector_i | input | CODE_W | Interrupt vector from the controller |
| ic_valid_i | input | 1 | Vector is valid for the presented mask |
| taken_o | output | 1 | One-cycle pulse: an event was entered |
| sr_o | output | XLEN | New status word |
| ssr_o | output | XLEN | Saved status word |
| spc_o | output | XLEN | Saved return address |
| sgr_o | output | XLEN | Saved register 15 |
| expevt_o | output | CODE_W | Last exception code |
| intevt_o | output | CODE_W | Last interrupt vector |
| pc_o | output | XLEN | Handler address |
| dslot_clr_o | output | 1 | Clear delay-slot flags (pulse) |
| sleep_clr_o | output | 1 | Clear sleep flag (pulse) |

## Verification
The bench aims at the overlaps: an exception and an interrupt together (a design with inverted priority would load INTEVT and jump to VBR+0x600), the block bit with and without sleep (a design that checks sleep on exceptions too would drop faults instead of forcing reset code 0x000), and code 0x1E0 under block, which must not be rewritten. It also combines a trap code with a delay slot, where the two 2-byte adjustments cancel and a design applying only one returns PC±2, and it holds the request high across the taken cycle, where a design that re-arms would save its own handler context a second time.

// File: rtl/exc_pkg.sv
package exc_pkg;

    // Status-word bit positions
    localparam int SR_MD_BIT    = 30;
    localparam int SR_RB_BIT    = 29;
    localparam int SR_BL_BIT    = 28;
    localparam int SR_FD_BIT    = 15;
    localparam int SR_IMASK_HI  = 7;
    localparam int SR_IMASK_LO  = 4;
    localparam int IMASK_W      = SR_IMASK_HI - SR_IMASK_LO + 1;

    // Event codes
    localparam int CODE_W_DEF    = 12;
    localparam logic [11:0] C_RESET    = 12'h000;
    localparam logic [11:0] C_MRESET   = 12'h020;
    localparam logic [11:0] C_MULTIHIT = 12'h140;
    localparam logic [11:0] C_MISS_RD  = 12'h040;
    localparam logic [11:0] C_MISS_WR  = 12'h060;
    localparam logic [11:0] C_TRAP     = 12'h160;
    localparam logic [11:0] C_BL_PASS  = 12'h1E0;

    // Handler offsets from the vector base
    localparam int OFS_GENERAL = 'h100;
    localparam int OFS_MISS    = 'h400;
    localparam int OFS_IRQ     = 'h600;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_EXC  = 2'd1,
        EV_IRQ  = 2'd2
    } ev_kind_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ENTRY = 1'b1
    } seq_state_e;

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              eval_i,
    input  logic              blocked_i,
    input  logic              sleep_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic              irq_req_i,
    input  logic              ic_valid_i,
    output ev_kind_e          kind_o,
    output logic [CODE_W-1:0] code_o
);

    localparam logic [CODE_W-1:0] NO_EXC = '1;

    logic exc_pend;
    logic irq_pend;

    assign exc_pend = (exc_code_i != NO_EXC);
    assign irq_pend = irq_req_i && !exc_pend;

    always_comb begin
        kind_o = EV_NONE;
        code_o = exc_code_i;
        if (eval_i) begin
            if (exc_pend) begin
                kind_o = EV_EXC;
                if (blocked_i && (exc_code_i != CODE_W'(C_BL_PASS))) begin
                    code_o = CODE_W'(C_RESET);
                end
            end else if (irq_pend) begin
                if ((!blocked_i || sleep_i) && ic_valid_i) begin
                    kind_o = EV_IRQ;
                end
            end
        end
    end

endmodule

// File: rtl/exc_vector_calc.sv
module exc_vector_calc
    import exc_pkg::*;
#(
    parameter int                XLEN     = 32,
    parameter int                CODE_W   = 12,
    parameter logic [XLEN-1:0]   RESET_PC = 32'hA000_0000
) (
    input  ev_kind_e          kind_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [XLEN-1:0]   sr_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   vbr_i,
    input  logic              in_dslot_i,
    output logic [XLEN-1:0]   sr_new_o,
    output logic [XLEN-1:0]   spc_new_o,
    output logic [XLEN-1:0]   pc_new_o
);

    logic is_reset_class;
    logic is_miss_class;
    logic is_trap;
    logic [XLEN-1:0] ret_base;

    assign is_reset_class = (code_i == CODE_W'(C_RESET)) ||
                            (code_i == CODE_W'(C_MRESET)) ||
                            (code_i == CODE_W'(C_MULTIHIT));
    assign is_miss_class  = (code_i == CODE_W'(C_MISS_RD)) ||
                            (code_i == CODE_W'(C_MISS_WR));
    assign is_trap        = (code_i == CODE_W'(C_TRAP));

    assign ret_base = in_dslot_i ? (pc_i - XLEN'(2)) : pc_i;

    always_comb begin
        sr_new_o = sr_i;
        sr_new_o[SR_MD_BIT] = 1'b1;
        sr_new_o[SR_RB_BIT] = 1'b1;
        sr_new_o[SR_BL_BIT] = 1'b1;
        spc_new_o = ret_base;
        pc_new_o  = pc_i;
        unique case (kind_i)
            EV_EXC: begin
                if (is_reset_class) begin
                    sr_new_o[SR_FD_BIT] = 1'b0;
                    sr_new_o[SR_IMASK_HI:SR_IMASK_LO] = '1;
                    pc_new_o = RESET_PC;
                end else if (is_miss_class) begin
                    pc_new_o = vbr_i + XLEN'(OFS_MISS);
                end else begin
                    if (is_trap) begin
                        spc_new_o = ret_base + XLEN'(2);
                    end
                    pc_new_o = vbr_i + XLEN'(OFS_GENERAL);
                end
            end
            EV_IRQ: begin
                pc_new_o = vbr_i + XLEN'(OFS_IRQ);
            end
            default: begin
                pc_new_o = pc_i;
            end
        endcase
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              CODE_W   = 12,
    parameter logic [XLEN-1:0] RESET_PC = 32'hA000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_i,
    input  logic [XLEN-1:0]   sr_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   r15_i,
    input  logic [XLEN-1:0]   vbr_i,
    input  logic              in_dslot_i,
    input  logic              sleep_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic              irq_req_i,
    output logic [3:0]        ic_imask_o,
    input  logic [CODE_W-1:0] ic_vector_i,
    input  logic              ic_valid_i,
    output logic              taken_o,
    output logic [XLEN-1:0]   sr_o,
    output logic [XLEN-1:0]   ssr_o,
    output logic [XLEN-1:0]   spc_o,
    output logic [XLEN-1:0]   sgr_o,
    output logic [CODE_W-1:0] expevt_o,
    output logic [CODE_W-1:0] intevt_o,
    output logic [XLEN-1:0]   pc_o,
    output logic              dslot_clr_o,
    output logic              sleep_clr_o
);

    localparam logic [CODE_W-1:0] NO_EXC = '1;

    seq_state_e state_q, state_d;
    ev_kind_e   kind_now;
    ev_kind_e   kind_q;
    logic [CODE_W-1:0] code_now;
    logic [XLEN-1:0]   sr_new, spc_new, pc_new;
    logic              dslot_q;
    logic              commit;

    assign ic_imask_o = sr_i[SR_IMASK_HI:SR_IMASK_LO];

    exc_arbiter #(
        .CODE_W (CODE_W)
    ) u_arb (
        .eval_i     (eval_i && (state_q == ST_IDLE)),
        .blocked_i  (sr_i[SR_BL_BIT]),
        .sleep_i    (sleep_i),
        .exc_code_i (exc_code_i),
        .irq_req_i  (irq_req_i),
        .ic_valid_i (ic_valid_i),
        .kind_o     (kind_now),
        .code_o     (code_now)
    );

    exc_vector_calc #(
        .XLEN     (XLEN),
        .CODE_W   (CODE_W),
        .RESET_PC (RESET_PC)
    ) u_vec (
        .kind_i     (kind_now),
        .code_i     (code_now),
        .sr_i       (sr_i),
        .pc_i       (pc_i),
        .vbr_i      (vbr_i),
        .in_dslot_i (in_dslot_i),
        .sr_new_o   (sr_new),
        .spc_new_o  (spc_new),
        .pc_new_o   (pc_new)
    );

    assign commit = (state_q == ST_IDLE) && (kind_now != EV_NONE);

    // Next-state: T_HOLD, T_COMMIT, T_RETURN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = commit ? ST_ENTRY : ST_IDLE;
            ST_ENTRY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Architectural outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_o     <= '0;
            ssr_o    <= '0;
            spc_o    <= '0;
            sgr_o    <= '0;
            pc_o     <= '0;
            expevt_o <= '0;
            intevt_o <= '0;
            dslot_q  <= 1'b0;
            kind_q   <= EV_NONE;
        end else if (commit) begin
            sr_o    <= sr_new;
            ssr_o   <= sr_i;
            spc_o   <= spc_new;
            sgr_o   <= r15_i;
            pc_o    <= pc_new;
            dslot_q <= in_dslot_i;
            kind_q  <= kind_now;
            if (kind_now == EV_EXC) begin
                expevt_o <= code_now;
            end else begin
                intevt_o <= ic_vector_i;
            end
        end
    end

    assign taken_o     = (state_q == ST_ENTRY);
    assign sleep_clr_o = taken_o;
    assign dslot_clr_o = taken_o && dslot_q;

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |=> !taken_o); // R11

    AST_REQ_DURING_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |=> $stable(pc_o) && $stable(ssr_o)); // R11

    AST_EXC_BEATS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && !taken_o && (exc_code_i != NO_EXC)) |=> (taken_o && kind_q == EV_EXC)); // R1

    AST_BL_MASKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && !taken_o && sr_i[SR_BL_BIT] && !sleep_i && (exc_code_i == NO_EXC))
        |=> !taken_o); // R3

    AST_CONTEXT_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && !taken_o && (kind_now != EV_NONE))
        |=> (ssr_o == $past(sr_i)) && (sgr_o == $past(r15_i))); // R5

    AST_ENTRY_SR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> (sr_o[SR_MD_BIT] && sr_o[SR_RB_BIT] && sr_o[SR_BL_BIT])); // R5

    AST_IRQ_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && !taken_o && (exc_code_i == NO_EXC) && !ic_valid_i) |=> !taken_o); // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!taken_o && !(eval_i && (exc_code_i != NO_EXC || irq_req_i)))
        |=> !taken_o && $stable(pc_o) && $stable(expevt_o)); // R12

endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb_top;

    localparam int XLEN   = 32;
    localparam int CODE_W = 12;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              eval_i;
    logic [XLEN-1:0]   sr_i, pc_i, r15_i, vbr_i;
    logic              in_dslot_i, sleep_i, irq_req_i, ic_valid_i;
    logic [CODE_W-1:0] exc_code_i, ic_vector_i;
    logic [3:0]        ic_imask_o;
    logic              taken_o, dslot_clr_o, sleep_clr_o;
    logic [XLEN-1:0]   sr_o, ssr_o, spc_o, sgr_o, pc_o;
    logic [CODE_W-1:0] expevt_o, intevt_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // expected architectural state
    logic [XLEN-1:0]   e_sr, e_ssr, e_spc, e_sgr, e_pc;
    logic [CODE_W-1:0] e_expevt, e_intevt;
    logic              e_took, e_dclr;

    always #2 clk = ~clk; // 250 MHz

    exc_entry_seq #(.XLEN(XLEN), .CODE_W(CODE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .sr_i(sr_i), .pc_i(pc_i),
        .r15_i(r15_i), .vbr_i(vbr_i), .in_dslot_i(in_dslot_i), .sleep_i(sleep_i),
        .exc_code_i(exc_code_i), .irq_req_i(irq_req_i), .ic_imask_o(ic_imask_o),
        .ic_vector_i(ic_vector_i), .ic_valid_i(ic_valid_i), .taken_o(taken_o),
        .sr_o(sr_o), .ssr_o(ssr_o), .spc_o(spc_o), .sgr_o(sgr_o),
        .expevt_o(expevt_o), .intevt_o(intevt_o), .pc_o(pc_o),
        .dslot_clr_o(dslot_clr_o), .sleep_clr_o(sleep_clr_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model from the requirements
    task automatic model_step();
        logic exc_p, irq_p, take_exc, take_irq;
        logic [CODE_W-1:0] c;
        logic [XLEN-1:0] base;
        exc_p = (exc_code_i != 12'hFFF);                  // R12
        irq_p = irq_req_i && !exc_p;                      // R1
        c = exc_code_i;
        take_exc = exc_p;
        take_irq = irq_p && ic_valid_i;                   // R4
        if (sr_i[28]) begin
            if (exc_p && c != 12'h1E0) c = 12'h000;        // R2
            if (irq_p && !sleep_i) take_irq = 1'b0;       // R3
        end
        e_took = take_exc || take_irq;
        e_dclr = e_took && in_dslot_i;
        if (e_took) begin
            e_ssr = sr_i; e_sgr = r15_i;                  // R5
            e_sr = sr_i | 32'h7000_0000;
            base = in_dslot_i ? pc_i - 2 : pc_i;          // R6
            e_spc = base;
            if (take_exc) begin
                e_expevt = c;
                if (c == 12'h000 || c == 12'h020 || c == 12'h140) begin // R7
                    e_sr[15] = 1'b0; e_sr[7:4] = 4'hF; e_pc = 32'hA000_0000;
                end else if (c == 12'h040 || c == 12'h060) begin        // R8
                    e_pc = vbr_i + 32'h400;
                end else begin
                    if (c == 12'h160) e_spc = base + 2;    // R9
                    e_pc = vbr_i + 32'h100;
                end
            end else begin
                e_intevt = ic_vector_i;                   // R10
                e_pc = vbr_i + 32'h600;
            end
        end
    endtask

    task automatic compare_all(input string ctx);
        chk({ctx, " R11 taken"}, 32'(taken_o), 32'(e_took));
        chk({ctx, " R11 sleep_clr"}, 32'(sleep_clr_o), 32'(e_took));
        chk({ctx, " R6 dslot_clr"}, 32'(dslot_clr_o), 32'(e_dclr));
        chk({ctx, " R5 sr"}, sr_o, e_sr);
        chk({ctx, " R5 ssr"}, ssr_o, e_ssr);
        chk({ctx, " R5 sgr"}, sgr_o, e_sgr);
        chk({ctx, " R6 spc"}, spc_o, e_spc);
        chk({ctx, " R8 pc"}, pc_o, e_pc);
        chk({ctx, " R8 expevt"}, 32'(expevt_o), 32'(e_expevt));
        chk({ctx, " R10 intevt"}, 32'(intevt_o), 32'(e_intevt));
    endtask

    // one evaluation: inputs already set; drive eval at negedge, sample next negedge
    task automatic apply(input string ctx);
        chk({ctx, " R4 imask"}, 32'(ic_imask_o), 32'(sr_i[7:4]));
        model_step();
        eval_i = 1'b1;
        @(negedge clk);
        eval_i = 1'b0;
        compare_all(ctx);
        @(negedge clk);
        chk({ctx, " R11 one-cycle"}, 32'(taken_o), 32'd0);
    endtask

    task automatic set_in(input logic [31:0] sr, input logic [11:0] code,
                          input logic irq, input logic icv, input logic slp, input logic ds);
        sr_i = sr; exc_code_i = code; irq_req_i = irq; ic_valid_i = icv;
        sleep_i = slp; in_dslot_i = ds;
        pc_i = 32'h0C00_1000 + {$urandom_range(0, 4095), 1'b0};
        r15_i = $urandom; vbr_i = {$urandom_range(0, 65535), 16'h0};
        ic_vector_i = 12'($urandom_range(16'h200, 16'h3E0));
    endtask

    function automatic logic [11:0] pick_code();
        case ($urandom_range(0, 11))
            0: return 12'h000;  1: return 12'h020;  2: return 12'h140;
            3: return 12'h040;  4: return 12'h060;  5: return 12'h160;
            6: return 12'h1E0;  7: return 12'h0A0;  8: return 12'h180;
            default: return 12'hFFF;
        endcase
    endfunction

    initial begin
        void'($urandom(32'h0000_5EED));
        rst_n = 1'b0; eval_i = 1'b0;
        set_in(32'h0, 12'hFFF, 1'b0, 1'b0, 1'b0, 1'b0);
        e_sr = '0; e_ssr = '0; e_spc = '0; e_sgr = '0; e_pc = '0;
        e_expevt = '0; e_intevt = '0; e_took = 1'b0; e_dclr = 1'b0;
        repeat (3) @(negedge clk);
        compare_all("reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R1: exception and interrupt together, exception wins
        set_in(32'h0000_00F0, 12'h0A0, 1'b1, 1'b1, 1'b0, 1'b0); apply("R1 prio");
        // R2: block bit rewrites code to reset
        set_in(32'h1000_8030, 12'h180, 1'b0, 1'b0, 1'b0, 1'b0); apply("R2 bl->reset");
        // R2: code 0x1E0 passes under block
        set_in(32'h1000_0000, 12'h1E0, 1'b0, 1'b0, 1'b0, 1'b0); apply("R2 1E0 pass");
        // R3: irq under block without sleep ignored
        set_in(32'h1000_0000, 12'hFFF, 1'b1, 1'b1, 1'b0, 1'b0); apply("R3 masked");
        // R3: irq under block while sleeping taken
        set_in(32'h1000_0000, 12'hFFF, 1'b1, 1'b1, 1'b1, 1'b0); apply("R3 sleep");
        // R4: controller gives no vector
        set_in(32'h0000_0050, 12'hFFF, 1'b1, 1'b0, 1'b0, 1'b0); apply("R4 novalid");
        // R6, R9: trap in delay slot, adjustments cancel
        set_in(32'h0000_0000, 12'h160, 1'b0, 1'b0, 1'b0, 1'b1); apply("R9 trap ds");
        // R7: multi-hit code resets mask and FD
        set_in(32'h0000_8000, 12'h140, 1'b0, 1'b0, 1'b0, 1'b1); apply("R7 multihit");
        // R8: miss vector
        set_in(32'h4000_0000, 12'h060, 1'b0, 1'b0, 1'b0, 1'b0); apply("R8 miss");
        // R10: plain interrupt
        set_in(32'h0000_0020, 12'hFFF, 1'b1, 1'b1, 1'b0, 1'b0); apply("R10 irq");
        // R12: nothing pending
        set_in(32'h0000_0000, 12'hFFF, 1'b0, 1'b1, 1'b0, 1'b0); apply("R12 idle");

        // R11: request held through the taken cycle is ignored
        set_in(32'h0000_0000, 12'h040, 1'b0, 1'b0, 1'b0, 1'b0);
        model_step();
        eval_i = 1'b1;
        @(negedge clk);
        compare_all("R11 first");
        set_in(32'h0000_0000, 12'h0A0, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        eval_i = 1'b0;
        e_took = 1'b0; e_dclr = 1'b0;
        compare_all("R11 held");
        @(negedge clk);

        // random mix
        for (int i = 0; i < 400; i++) begin
            set_in({1'b0, $urandom_range(0, 9) < 3 ? 1'b0 : 1'b0,
                    2'($urandom_range(0, 3)), ($urandom_range(0, 9) < 3),
                    12'($urandom), 16'($urandom)} ,
                   pick_code(), 1'($urandom_range(0, 1)), ($urandom_range(0, 3) != 0),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            apply("rand");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R11 actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule